// File: doc/BRIEF.md
# Local Bus Cycle Control Generator

This block sequences one master on a multiplexed local address/data bus and drives the control strobes that go with each bus cycle. A request is presented as a start level together with a direction, a data-or-instruction flag, an atomic flag and a burst length. The request is taken combinationally in the idle state. The cycle then runs one address state and, for each data beat, wait states until ready is sampled high followed by one data state. A parameterised recovery period ends the cycle.

An atomic request runs as a locked read-modify-write pair. A full read phase is followed at once by a full write phase, with no idle state in between. The lock output is held low from the first address state until the last data state of the write phase. An external agent can ask for the bus with a hold request. It is granted only when the bus is idle and unlocked, and new requests wait until the hold is released.

Top module: `lbc_ctrl`

## Requirements
- R1: During and straight after reset, the outputs are at rest: `ads_n`, `den_n` and `lock_n` high, and `dir_tx`, `cyc_dc`, `cyc_wr` and `hold_ack` low.
- R2: A taken request produces exactly one address state, with `ads_n` low for one clock. A burst length field of value L gives L+1 data beats. Each beat is a series of wait states that repeats until `bus_ready` is sampled high, followed by one data state.
- R3: `den_n` is low in every wait state and every data state and in no other state. It goes low in the clock after the address state and returns high after the last data state.
- R4: While a cycle runs, `dir_tx` is 1 for a write and 0 for a read. It is 0 in idle.
- R5: `dir_tx` never changes between two consecutive clocks in which `den_n` is low.
- R6: `cyc_dc` is 1 for a data access and 0 for an instruction access. `cyc_wr` is 1 for a write. Both are valid from the address state through recovery, share the same timing, and are 0 in idle.
- R7: An atomic request ignores `req_write`. It runs a read phase and then a write phase, each with L+1 beats, and the last read data state is followed directly by the second address state.
- R8: For an atomic request, `lock_n` is low from the first address state through the final data state of the write phase, which is 2·(1 + beats·(waits+2)) clocks. It is high in recovery and is never low for a plain request.
- R9: Recovery lasts RCV_CYC clocks and is followed by idle, where `req_take` rises when `req_start` is high. With waits W per beat, a plain cycle spans B+4 clocks from take to take and an atomic cycle spans 2B+5 clocks, where B = (L+1)(W+2).
- R10: If `hold_req` is high while the bus is idle and unlocked, `hold_ack` rises on the next clock. It stays high while `hold_req` stays high and falls on the clock after `hold_req` is released.
- R11: `hold_ack` is never high while `lock_n` is low. A hold requested during an atomic pair is granted on the clock after the bus first returns to idle.
- R12: `req_take` stays low while `hold_req` or `hold_ack` is high. When a hold request and a start arrive together in idle, the hold wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request present; held until `req_take` |
| req_write | input | 1 | 1 = write, 0 = read (ignored for atomic) |
| req_data | input | 1 | 1 = data access, 0 = instruction access |
| req_atomic | input | 1 | Locked read-then-write pair |
| req_len | input | LEN_W | Number of data beats minus one |
| req_take | output | 1 | Request accepted at this clock edge |
| bus_ready | input | 1 | Ready, sampled in wait states |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Hold granted |
| ads_n | output | 1 | Address state strobe, active low |
| den_n | output | 1 | Data enable, active low |
| dir_tx | output | 1 | Direction: 1 transmit, 0 receive |
| cyc_dc | output | 1 | 1 data, 0 instruction |
| cyc_wr | output | 1 | 1 write, 0 read |
| lock_n | output | 1 | Atomic lock window, active low |

## Verification
The bench builds the block with LEN_W = 2 and RCV_CYC = 2, so bursts of one to four beats can be reached. Take-to-take spans stay short enough to be written as exact constants in a vector table. A responder inserts zero to three wait states per beat, which moves the data-enable window and the lock window by known amounts, including for atomic pairs with bursts. Directed tests raise the hold request in idle, together with a start, and in the middle of a lock window, so that the grant timing and the stall are observed at the ports.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_RCV  = 3'd4
  } lbc_state_e;

  typedef struct packed {
    logic wr;
    logic dc;
    logic atomic;
  } lbc_op_t;

endpackage

// File: rtl/lbc_fsm.sv
module lbc_fsm
  import lbc_pkg::*;
#(
  parameter int LEN_W   = 2,
  parameter int RCV_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic             data_i,
  input  logic             atomic_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ready_i,
  input  logic             hold_block_i,
  output logic             take_o,
  output lbc_state_e       state_o,
  output lbc_op_t          op_o
);

  localparam int RCV_W = (RCV_CYC > 1) ? $clog2(RCV_CYC) : 1;
  localparam logic [RCV_W-1:0] RCV_LAST = RCV_W'(RCV_CYC - 1);

  lbc_state_e       st_q, st_d;
  lbc_op_t          op_q, op_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [RCV_W-1:0] rcv_q, rcv_d;
  logic             op_en, len_en, beat_en, rcv_en;
  logic             last_beat, turn;

  assign last_beat = (beat_q == len_q);
  assign turn      = (st_q == ST_DATA) && last_beat && op_q.atomic && !op_q.wr;
  assign take_o    = (st_q == ST_IDLE) && start_i && !hold_block_i;

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    len_d   = len_q;
    beat_d  = beat_q;
    rcv_d   = rcv_q;
    op_en   = 1'b0;
    len_en  = 1'b0;
    beat_en = 1'b0;
    rcv_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (take_o) begin
          st_d      = ST_ADDR;
          op_en     = 1'b1;
          op_d.wr   = atomic_i ? 1'b0 : write_i;
          op_d.dc   = data_i;
          op_d.atomic = atomic_i;
          len_en    = 1'b1;
          len_d     = len_i;
          beat_en   = 1'b1;
          beat_d    = '0;
        end
      end
      ST_ADDR: st_d = ST_WAIT;
      ST_WAIT: if (ready_i) st_d = ST_DATA;
      ST_DATA: begin
        beat_en = 1'b1;
        if (!last_beat) begin
          st_d   = ST_WAIT;
          beat_d = beat_q + 1'b1;
        end else if (turn) begin
          st_d    = ST_ADDR;
          op_en   = 1'b1;
          op_d.wr = 1'b1;
          beat_d  = '0;
        end else begin
          st_d   = ST_RCV;
          rcv_en = 1'b1;
          rcv_d  = '0;
        end
      end
      ST_RCV: begin
        if (rcv_q == RCV_LAST) begin
          st_d = ST_IDLE;
        end else begin
          rcv_en = 1'b1;
          rcv_d  = rcv_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      len_q  <= '0;
      beat_q <= '0;
      rcv_q  <= '0;
    end else begin
      st_q <= st_d;
      if (op_en)   op_q   <= op_d;
      if (len_en)  len_q  <= len_d;
      if (beat_en) beat_q <= beat_d;
      if (rcv_en)  rcv_q  <= rcv_d;
    end
  end

  assign state_o = st_q;
  assign op_o    = op_q;

  // R2: a wait state without ready is followed by another wait state
  p_wait_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !ready_i) |=> (st_q == ST_WAIT));

  // R2: an address state is always followed by a wait state
  p_addr_then_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |=> (st_q == ST_WAIT));

  // R7: the last read beat of an atomic pair leads straight to the write address state
  p_atomic_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    turn |=> (st_q == ST_ADDR && op_q.wr && op_q.atomic));

  // R9: recovery ends in idle after its final count
  p_rcv_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RCV && rcv_q == RCV_LAST) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/lbc_strobe.sv
module lbc_strobe
  import lbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lbc_state_e state_i,
  input  lbc_op_t    op_i,
  output logic       ads_n,
  output logic       den_n,
  output logic       dir_tx,
  output logic       cyc_dc,
  output logic       cyc_wr,
  output logic       lock_n
);

  logic active, in_data, in_xfer;

  assign active  = (state_i != ST_IDLE);
  assign in_data = (state_i == ST_WAIT) || (state_i == ST_DATA);
  assign in_xfer = (state_i == ST_ADDR) || in_data;

  assign ads_n  = !(state_i == ST_ADDR);
  assign den_n  = !in_data;
  assign dir_tx = active && op_i.wr;
  assign cyc_wr = active && op_i.wr;
  assign cyc_dc = active && op_i.dc;
  assign lock_n = !(in_xfer && op_i.atomic);

  // R5: direction frozen across consecutive data-enable clocks
  p_dir_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && $past(!den_n)) |-> $stable(dir_tx));

  // R8: lock released during recovery
  p_lock_free_rcv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_RCV) |-> lock_n);

  // R3: address strobe and data enable never overlap
  p_ads_den_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ads_n && !den_n));

endmodule

// File: rtl/lbc_hold.sv
module lbc_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_idle_i,
  input  logic lock_active_i,
  input  logic hold_req_i,
  output logic hold_ack_o
);

  logic ack_q, ack_d;

  always_comb begin
    if (ack_q) ack_d = hold_req_i;
    else       ack_d = hold_req_i && bus_idle_i && !lock_active_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign hold_ack_o = ack_q;

  // R10: idle, unlocked bus grants a waiting hold on the next clock
  p_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req_i && bus_idle_i && !lock_active_i) |=> hold_ack_o);

  // R10: release of the request drops the grant next clock
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack_o && !hold_req_i) |=> !hold_ack_o);

  // R11: no grant inside a lock window
  p_no_ack_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_ack_o && lock_active_i));

endmodule

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
#(
  parameter int LEN_W   = 2,
  parameter int RCV_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_write,
  input  logic             req_data,
  input  logic             req_atomic,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_take,
  input  logic             bus_ready,
  input  logic             hold_req,
  output logic             hold_ack,
  output logic             ads_n,
  output logic             den_n,
  output logic             dir_tx,
  output logic             cyc_dc,
  output logic             cyc_wr,
  output logic             lock_n
);

  lbc_state_e state;
  lbc_op_t    op;
  logic       hold_block;

  assign hold_block = hold_req || hold_ack;

  lbc_fsm #(.LEN_W(LEN_W), .RCV_CYC(RCV_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (req_start),
    .write_i      (req_write),
    .data_i       (req_data),
    .atomic_i     (req_atomic),
    .len_i        (req_len),
    .ready_i      (bus_ready),
    .hold_block_i (hold_block),
    .take_o       (req_take),
    .state_o      (state),
    .op_o         (op)
  );

  lbc_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state),
    .op_i    (op),
    .ads_n   (ads_n),
    .den_n   (den_n),
    .dir_tx  (dir_tx),
    .cyc_dc  (cyc_dc),
    .cyc_wr  (cyc_wr),
    .lock_n  (lock_n)
  );

  lbc_hold u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_idle_i    (state == ST_IDLE),
    .lock_active_i (!lock_n),
    .hold_req_i    (hold_req),
    .hold_ack_o    (hold_ack)
  );

  // R12: no request is taken while a hold is pending or granted
  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req || hold_ack) |-> !req_take);

endmodule

// File: tb/sim_lbc_ctrl.sv
`timescale 1ns/1ps
module sim_lbc_ctrl;

  localparam int LEN_W = 2;
  localparam int NV    = 9;

  logic clk, rst_n;
  logic req_start, req_write, req_data, req_atomic;
  logic [LEN_W-1:0] req_len;
  logic req_take, bus_ready, hold_req, hold_ack;
  logic ads_n, den_n, dir_tx, cyc_dc, cyc_wr, lock_n;

  lbc_ctrl #(.LEN_W(LEN_W), .RCV_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_data(req_data), .req_atomic(req_atomic), .req_len(req_len),
    .req_take(req_take), .bus_ready(bus_ready), .hold_req(hold_req),
    .hold_ack(hold_ack), .ads_n(ads_n), .den_n(den_n), .dir_tx(dir_tx),
    .cyc_dc(cyc_dc), .cyc_wr(cyc_wr), .lock_n(lock_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {write, data, atomic, len, waits, take-to-take clocks, den clocks, lock clocks}
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd6,  8'd2,  8'd0},
    {1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 8'd8,  8'd4,  8'd0},
    {1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 8'd12, 8'd8,  8'd0},
    {1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 8'd10, 8'd6,  8'd0},
    {1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 8'd9,  8'd4,  8'd6},
    {1'b0, 1'b1, 1'b1, 2'd1, 2'd1, 8'd17, 8'd12, 8'd14},
    {1'b1, 1'b1, 1'b0, 2'd3, 2'd3, 8'd24, 8'd20, 8'd0},
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 8'd15, 8'd10, 8'd12},
    {1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 8'd6,  8'd2,  8'd0}
  };

  int n_chk = 0, n_fail = 0;
  int den_cnt, lock_cnt, ads_cnt, dir_bad, attr_bad, hold_bad;
  int run_wait, rsp_cnt;
  logic rsp_data, run_wr, run_dc, run_at, prev_den, prev_dir;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    den_cnt = 0; lock_cnt = 0; ads_cnt = 0;
    dir_bad = 0; attr_bad = 0; hold_bad = 0;
  endtask

  // one clock: observe at the falling edge, then answer with ready
  task automatic cycle();
    logic exp_wr;
    @(negedge clk);
    if (!den_n) den_cnt++;
    if (!lock_n) lock_cnt++;
    if (hold_ack && !lock_n) hold_bad++;
    if (!den_n && prev_den && dir_tx != prev_dir) dir_bad++;
    if (!ads_n) begin
      ads_cnt++;
      exp_wr = run_at ? (ads_cnt == 2) : run_wr;
      if (cyc_dc != run_dc || cyc_wr != exp_wr || dir_tx != exp_wr) attr_bad++;
    end
    if (!den_n && (dir_tx != cyc_wr || cyc_dc != run_dc)) attr_bad++;
    prev_den = !den_n;
    prev_dir = dir_tx;
    if (!den_n) begin
      if (rsp_data) begin
        rsp_data = 1'b0; rsp_cnt = 0; bus_ready = 1'b0;
      end else if (rsp_cnt == run_wait) begin
        bus_ready = 1'b1; rsp_data = 1'b1;
      end else begin
        bus_ready = 1'b0; rsp_cnt++;
      end
    end else begin
      bus_ready = 1'b0; rsp_cnt = 0; rsp_data = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    int prev;
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_data = 1'b0;
    req_atomic = 1'b0; req_len = '0; bus_ready = 1'b0; hold_req = 1'b0;
    rsp_cnt = 0; rsp_data = 1'b0; run_wait = 0; prev_den = 1'b0; prev_dir = 1'b0;
    run_wr = 1'b0; run_dc = 1'b0; run_at = 1'b0;
    clr();
    repeat (3) @(negedge clk);
    // R1: outputs at rest during reset
    chk(ads_n && den_n && lock_n && !dir_tx && !cyc_dc && !cyc_wr && !hold_ack,
        "R1 in reset", {ads_n, den_n, lock_n, dir_tx, cyc_dc, cyc_wr, hold_ack}, 7'b1110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ads_n && den_n && lock_n && !dir_tx && !cyc_dc && !cyc_wr && !hold_ack,
        "R1 after reset", {ads_n, den_n, lock_n, dir_tx, cyc_dc, cyc_wr, hold_ack}, 7'b1110000);

    // table walk: each take closes out the previous vector's checks
    prev = -1;
    cyc = 0;
    for (int i = 0; i < NV; i++) begin
      req_write  = VEC[i][30];
      req_data   = VEC[i][29];
      req_atomic = VEC[i][28];
      req_len    = VEC[i][27:26];
      req_start  = 1'b1;
      while (!req_take && cyc < 200) begin
        cycle();
        cyc++;
      end
      if (prev >= 0) begin
        chk(cyc == int'(VEC[prev][23:16]), $sformatf("R9 span v%0d", prev), cyc, int'(VEC[prev][23:16]));
        chk(den_cnt == int'(VEC[prev][15:8]), $sformatf("R3 den v%0d", prev), den_cnt, int'(VEC[prev][15:8]));
        chk(lock_cnt == int'(VEC[prev][7:0]), $sformatf("R8 lock v%0d", prev), lock_cnt, int'(VEC[prev][7:0]));
        chk(ads_cnt == (VEC[prev][28] ? 2 : 1), $sformatf("R2 R7 ads v%0d", prev), ads_cnt, VEC[prev][28] ? 2 : 1);
        chk(dir_bad == 0, $sformatf("R5 dir v%0d", prev), dir_bad, 0);
        chk(attr_bad == 0, $sformatf("R4 R6 attr v%0d", prev), attr_bad, 0);
        chk(hold_bad == 0, $sformatf("R11 v%0d", prev), hold_bad, 0);
      end
      clr();
      run_wr = VEC[i][30]; run_dc = VEC[i][29]; run_at = VEC[i][28];
      run_wait = int'(VEC[i][25:24]);
      prev = i;
      cycle();
      cyc = 1;
    end
    req_start = 1'b0;
    repeat (10) cycle();

    // R10 R12: hold granted in idle, start stalled until release
    hold_req = 1'b1;
    cycle();
    chk(hold_ack == 1'b1, "R10 grant", hold_ack, 1);
    req_start = 1'b1; req_atomic = 1'b0; req_write = 1'b0; req_len = '0;
    clr();
    for (int k = 0; k < 4; k++) begin
      chk(req_take == 1'b0, "R12 stalled", req_take, 0);
      cycle();
    end
    chk(ads_cnt == 0 && hold_ack, "R12 no cycle under hold", ads_cnt, 0);
    hold_req = 1'b0;
    chk(req_take == 1'b0, "R12 ack still high", req_take, 0);
    cycle();
    chk(hold_ack == 1'b0, "R10 release", hold_ack, 0);
    chk(req_take == 1'b1, "R12 resumes", req_take, 1);
    run_wr = 1'b0; run_dc = req_data; run_at = 1'b0; run_wait = 0;
    cycle();
    req_start = 1'b0;
    repeat (8) cycle();

    // R12: hold and start together in idle, hold wins
    hold_req = 1'b1; req_start = 1'b1;
    #1;
    chk(req_take == 1'b0, "R12 hold wins", req_take, 1'b0);
    cycle();
    chk(hold_ack == 1'b1 && ads_n, "R12 R10 grant not cycle", hold_ack, 1);
    req_start = 1'b0; hold_req = 1'b0;
    repeat (3) cycle();

    // R11: hold raised inside an atomic pair is granted once idle again
    req_atomic = 1'b1; req_len = '0; req_data = 1'b1; req_start = 1'b1;
    #1;
    chk(req_take == 1'b1, "R11 atomic taken", req_take, 1);
    run_at = 1'b1; run_dc = 1'b1; run_wait = 0;
    clr();
    cycle();
    req_start = 1'b0; hold_req = 1'b1;
    cyc = 1;
    while (!hold_ack && cyc < 40) begin
      cycle();
      cyc++;
    end
    chk(cyc == 10, "R11 grant clock", cyc, 10);
    chk(hold_bad == 0 && lock_cnt == 6, "R11 R8 lock kept clean", lock_cnt, 6);
    hold_req = 1'b0;
    repeat (3) cycle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule